// File: doc/BRIEF.md
# Guarded Nonvolatile Write Controller

This block sits between a register bus and a small byte-addressable nonvolatile data array. Software sets an address and a data byte. It then has to pass three gates before a cell write starts. The write-enable control bit must already be set. A two-value unlock key must have just been written to the key register. The write-start bit must then be set. Writes are also refused during a fixed power-up lockout window after reset. A refused start sets a sticky error flag and nothing else happens.

The same register bus carries accesses from the core and from an external programming port, and a source qualifier marks each access. With the code-protect input high, every external-port access is dropped: writes change nothing and reads return zero. Core accesses keep working whatever the code-protect setting. The array model takes a configurable number of clock cycles to complete a write. While the write runs, the write-start bit reads as set. A one-cycle done pulse marks the cycle in which that bit clears. A read is started from the control register and loads the addressed byte into the data register.

Register map (`reg_sel`): 0 = address, 1 = data, 2 = control, 3 = key. Control bits: bit0 write enable, bit1 write start / busy, bit2 read start (always reads 0), bit3 write error. Writing 1 to bit3 clears the error. All other control bits read 0.

Top module: `nvm_write_guard`

## Requirements
- R1: While reset is high and on the cycle after, the write-enable bit is 0 and `busy` is 0. After reset, the address, data and control registers read 0x00.
- R2: For PWRT_CYCLES cycles after reset is released, a write-start (control write with bit1 = 1) is refused even with a valid unlock and the enable bit set. `busy` stays 0 and the error bit (control bit3) is set.
- R3: A write starts when all of these hold: the write-enable bit is already 1, the key register receives 0x55, the very next bus access writes 0xAA to the key register, and a control write then has bit1 = 1. The array later holds the data byte at the address.
- R4: After 0x55 has been written to the key, the unlock returns to idle if the next bus access is anything other than a key write of 0xAA. This includes a read or a wrong key value. A later write-start is then refused.
- R5: A write-start without a valid unlock, or with the write-enable bit clear, is ignored and sets the error bit. The error bit stays set through other accesses until a control write with bit3 = 1 clears it.
- R6: After an accepted start, `busy` (and control bit1) stays high for exactly WR_LATENCY+1 cycles.
- R7: `write_done` is high for exactly one cycle: the first cycle in which `busy` is low again after a write.
- R8: The key register always reads 0x00.
- R9: Each write needs its own unlock. After a completed write, a second write-start with no new key sequence is refused and sets the error bit.
- R10: With `code_protect` = 1, accesses that have `ext_port` = 1 change no register, do not disturb the unlock sequence, and read as 0x00. With `code_protect` = 0, external accesses behave like core accesses.
- R11: Core accesses (`ext_port` = 0) read, write and unlock normally while `code_protect` = 1.
- R12: A control write with bit2 = 1 loads the byte at the current address into the data register. A data-register read two or more cycles later returns that byte.
- R13: Address or data register writes made while a write is busy do not change the byte or the location being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata after the next edge |
| reg_wdata | input | 8 | Write data |
| ext_port | input | 1 | Access comes from the external programming port |
| code_protect | input | 1 | Code protection on: external accesses are dropped |
| reg_rdata | output | 8 | Registered read data |
| busy | output | 1 | Write in progress (mirrors control bit1) |
| write_done | output | 1 | One-cycle pulse when a write completes |

## Verification
The assertions check several rules on every cycle:
- Each rise of `busy` was preceded by an armed unlock and falls outside the lockout.
- The done pulse coincides with `busy` falling.
- `busy` never drops before the array reports completion.
- The error flag stays sticky.
- Blocked external writes leave the registers untouched.
- A broken key sequence always returns to idle.

Only the directed scenarios show the end-to-end effects: the exact busy length in cycles, the array content seen through a read, that writes during busy do not disturb the write in progress, and that the key register reads as zero.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_KEY  = 2'd3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int CB_WEN    = 0;
  localparam int CB_WSTART = 1;
  localparam int CB_RSTART = 2;
  localparam int CB_WERR   = 3;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_state_t;
endpackage

// File: rtl/nvm_unlock_fsm.sv
module nvm_unlock_fsm
  import nvm_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_any,
  input  logic       acc_wr,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  input  logic       ctrl_wr,
  output logic       armed
);
  unlock_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      UL_IDLE: begin
        if (key_wr && key_val == KEY_FIRST) st_d = UL_HALF;
      end
      UL_HALF: begin
        if (acc_any) begin
          if (key_wr && key_val == KEY_SECOND) st_d = UL_ARMED;
          else                                 st_d = UL_IDLE;
        end
      end
      UL_ARMED: begin
        if (ctrl_wr)                                   st_d = UL_IDLE;
        else if (key_wr && key_val == KEY_FIRST)       st_d = UL_HALF;
        else if (acc_wr)                               st_d = UL_IDLE;
      end
      default: st_d = UL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= UL_IDLE;
    else     st_q <= st_d;
  end

  assign armed = (st_q == UL_ARMED);

  assert_abort_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == UL_HALF && acc_any && !(key_wr && key_val == KEY_SECOND)) |=> (st_q == UL_IDLE));

  assert_armed_from_half_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> ($past(st_q) == UL_HALF));
endmodule

// File: rtl/nvm_poweron_lock.sv
module nvm_poweron_lock #(
  parameter int PWRT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  output logic locked
);
  localparam int CW = $clog2(PWRT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PWRT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      locked <= 1'b1;
    end else begin
      if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      locked <= (cnt_q + 1'b1 < LIMIT) && (cnt_q != LIMIT);
    end
  end

  assert_lock_monotonic_R2: assert property (@(posedge clk) disable iff (rst)
    !locked |=> !locked);
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
  parameter int ADDR_W     = 6,
  parameter int WR_LATENCY = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              wr_done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(WR_LATENCY + 1);
  localparam logic [CW-1:0] LAT = CW'(WR_LATENCY);

  logic [7:0]        mem [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [7:0]        lat_data_q;
  logic              commit;

  assign commit = (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      wr_done    <= 1'b0;
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else begin
      wr_done <= commit;
      if (wr_start) begin
        cnt_q      <= LAT;
        lat_addr_q <= wr_addr;
        lat_data_q <= wr_data;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[lat_addr_q] <= lat_data_q;
    if (rd_en)  rd_data <= mem[rd_addr];
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> (cnt_q == '0));
endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int WR_LATENCY  = 8,
  parameter int PWRT_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  input  logic       ext_port,
  input  logic       code_protect,
  output logic [7:0] reg_rdata,
  output logic       busy,
  output logic       write_done
);
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              wen_q, busy_q, werr_q, done_q, rd_pend_q;
  logic              blocked, acc_wr, acc_rd, ctrl_wr, key_wr;
  logic              start_req, start_ok, start_bad, rd_start;
  logic              armed, locked, cell_done;
  logic [7:0]        cell_rd_data, rd_mux, addr_ext;

  assign blocked   = ext_port && code_protect;
  assign acc_wr    = reg_wr && !blocked;
  assign acc_rd    = reg_rd && !blocked;
  assign ctrl_wr   = acc_wr && (reg_sel == SEL_CTRL);
  assign key_wr    = acc_wr && (reg_sel == SEL_KEY);
  assign start_req = ctrl_wr && reg_wdata[CB_WSTART];
  assign start_ok  = start_req && armed && wen_q && !busy_q && !locked;
  assign start_bad = start_req && !start_ok;
  assign rd_start  = ctrl_wr && reg_wdata[CB_RSTART];

  nvm_unlock_fsm u_unlock (
    .clk     (clk),
    .rst     (rst),
    .acc_any (acc_wr || acc_rd),
    .acc_wr  (acc_wr),
    .key_wr  (key_wr),
    .key_val (reg_wdata),
    .ctrl_wr (ctrl_wr),
    .armed   (armed)
  );

  nvm_poweron_lock #(.PWRT_CYCLES(PWRT_CYCLES)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .locked (locked)
  );

  nvm_cell_array #(.ADDR_W(ADDR_W), .WR_LATENCY(WR_LATENCY)) u_cells (
    .clk      (clk),
    .rst      (rst),
    .wr_start (start_ok),
    .wr_addr  (addr_q),
    .wr_data  (data_q),
    .rd_en    (rd_start),
    .rd_addr  (addr_q),
    .rd_data  (cell_rd_data),
    .wr_done  (cell_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      data_q    <= '0;
      wen_q     <= 1'b0;
      busy_q    <= 1'b0;
      werr_q    <= 1'b0;
      done_q    <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      done_q    <= busy_q && cell_done;
      rd_pend_q <= rd_start;
      if (acc_wr && reg_sel == SEL_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
      if (acc_wr && reg_sel == SEL_DATA) data_q <= reg_wdata;
      else if (rd_pend_q)                data_q <= cell_rd_data;
      if (ctrl_wr) wen_q <= reg_wdata[CB_WEN];
      if (start_ok)       busy_q <= 1'b1;
      else if (cell_done) busy_q <= 1'b0;
      if (start_bad)                         werr_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[CB_WERR]) werr_q <= 1'b0;
    end
  end

  always_comb begin
    addr_ext = '0;
    addr_ext[ADDR_W-1:0] = addr_q;
    case (reg_sel)
      SEL_ADDR: rd_mux = addr_ext;
      SEL_DATA: rd_mux = data_q;
      SEL_CTRL: rd_mux = {4'b0, werr_q, 1'b0, busy_q, wen_q};
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= 8'h00;
    else if (reg_rd) reg_rdata <= blocked ? 8'h00 : rd_mux;
  end

  assign busy       = busy_q;
  assign write_done = done_q;

  assert_wen_reset_R1: assert property (@(posedge clk)
    rst |=> (!wen_q && !busy_q));

  assert_start_unlocked_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(!locked));

  assert_start_armed_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(armed && wen_q));

  assert_werr_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (werr_q && !(ctrl_wr && reg_wdata[CB_WERR])) |=> werr_q);

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !cell_done) |=> busy_q);

  assert_done_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));

  assert_fall_gives_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);

  assert_blocked_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (blocked && reg_wr && !rd_pend_q) |=> ($stable(addr_q) && $stable(data_q) && $stable(wen_q)));
endmodule

// File: tb/nvm_write_guard_bench.sv
`timescale 1ns/1ps
module nvm_write_guard_bench;
  localparam int ADDR_W = 6;
  localparam int LAT    = 8;
  localparam int PWRT   = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_sel = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       ext_port = 1'b0, code_protect = 1'b0;
  logic [7:0] reg_rdata;
  logic       busy, write_done;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  nvm_write_guard #(.ADDR_W(ADDR_W), .WR_LATENCY(LAT), .PWRT_CYCLES(PWRT)) u_nvm_write_guard (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .ext_port(ext_port), .code_protect(code_protect),
    .reg_rdata(reg_rdata), .busy(busy), .write_done(write_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] sel, input logic wr, input logic [7:0] d, input logic ext);
    reg_sel = sel; reg_wr = wr; reg_rd = !wr; reg_wdata = d; ext_port = ext;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; ext_port = 1'b0;
    rv = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    op(sel, 1'b1, d, 1'b0);
  endtask

  task automatic rd(input logic [1:0] sel);
    op(sel, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic unlock();
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hAA);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_err();
    wr(2'd2, 8'h09);
  endtask

  task automatic t_reset();
    check("R1 busy after reset", busy, 0);
    rd(2'd0); check("R1 addr reset", rv, 8'h00);
    rd(2'd1); check("R1 data reset", rv, 8'h00);
    rd(2'd2); check("R1 ctrl reset (wen clear)", rv, 8'h00);
  endtask

  task automatic t_lockout();
    wr(2'd2, 8'h01);
    unlock();
    wr(2'd2, 8'h03);
    check("R2 busy in lockout", busy, 0);
    rd(2'd2); check("R2 ctrl error in lockout", rv, 8'h09);
    clear_err();
    rd(2'd2); check("R5 error cleared by W1C", rv, 8'h01);
  endtask

  task automatic t_good_write();
    int cnt;
    wr(2'd0, 8'h05);
    wr(2'd1, 8'hA5);
    unlock();
    wr(2'd2, 8'h03);
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check("R6 busy length", cnt, LAT + 1);
    check("R7 done on busy fall", write_done, 1);
    @(negedge clk);
    check("R7 done one cycle", write_done, 0);
    rd(2'd2); check("R3 ctrl after write", rv, 8'h01);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h05);
    @(negedge clk);
    rd(2'd1); check("R12 R3 readback", rv, 8'hA5);
  endtask

  task automatic t_repeat();
    wr(2'd2, 8'h03);
    check("R9 no second write", busy, 0);
    rd(2'd2); check("R9 error set", rv, 8'h09);
    clear_err();
  endtask

  task automatic t_key_read();
    wr(2'd3, 8'h55);
    rd(2'd3); check("R8 key reads zero", rv, 8'h00);
    wr(2'd3, 8'hAA);
    wr(2'd2, 8'h03);
    check("R4 read aborts unlock", busy, 0);
    rd(2'd2); check("R4 error after read abort", rv, 8'h09);
    clear_err();
  endtask

  task automatic t_wrong_key();
    wr(2'd3, 8'h55);
    wr(2'd3, 8'h12);
    wr(2'd3, 8'hAA);
    wr(2'd2, 8'h03);
    check("R4 wrong key aborts", busy, 0);
    clear_err();
  endtask

  task automatic t_wen_clear();
    wr(2'd2, 8'h00);
    unlock();
    wr(2'd2, 8'h02);
    check("R5 no start with wen clear", busy, 0);
    rd(2'd2); check("R5 error with wen clear", rv, 8'h08);
    wr(2'd0, 8'h05);
    rd(2'd2); check("R5 error sticky", rv, 8'h08);
    clear_err();
    rd(2'd2); check("R5 error cleared", rv, 8'h01);
  endtask

  task automatic t_busy_writes();
    wr(2'd0, 8'h07);
    wr(2'd1, 8'h11);
    unlock();
    wr(2'd2, 8'h03);
    check("R3 start accepted", busy, 1);
    wr(2'd1, 8'hEE);
    wr(2'd0, 8'h02);
    wait_idle();
    wr(2'd0, 8'h07);
    wr(2'd2, 8'h05);
    @(negedge clk);
    rd(2'd1); check("R13 busy writes no effect", rv, 8'h11);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h05);
    @(negedge clk);
    rd(2'd1); check("R13 other address untouched", rv, 8'h00);
  endtask

  task automatic t_protect();
    code_protect = 1'b1;
    wr(2'd0, 8'h07);
    op(2'd0, 1'b1, 8'h09, 1'b1);
    rd(2'd0); check("R10 ext write dropped", rv, 8'h07);
    op(2'd0, 1'b0, 8'h00, 1'b1); check("R10 ext read zero", rv, 8'h00);
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h3C);
    wr(2'd3, 8'h55);
    op(2'd3, 1'b1, 8'h00, 1'b1);
    wr(2'd3, 8'hAA);
    wr(2'd2, 8'h03);
    check("R10 R11 blocked access keeps unlock", busy, 1);
    wait_idle();
    wr(2'd2, 8'h05);
    @(negedge clk);
    rd(2'd1); check("R11 core write under protect", rv, 8'h3C);
    code_protect = 1'b0;
    op(2'd0, 1'b0, 8'h00, 1'b1); check("R10 ext read unprotected", rv, 8'h09);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lockout();
    repeat (PWRT + 16) @(negedge clk);
    t_good_write();
    t_repeat();
    t_key_read();
    t_wrong_key();
    t_wen_clear();
    t_busy_writes();
    t_protect();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule